// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block sits behind the clock recovery of a 100 Mb/s twisted-pair receiver. It takes one recovered NRZ bit per 125 MHz clock and removes the line scrambling. To do this it locks a local 11-bit key generator onto the all-ones idle stream that arrives between frames. Once locked, it waits for the first zero. It then uses the start-delimiter pair to fix where each 5-bit code group begins. It turns each data group into a 4-bit nibble and raises a one-cycle valid strobe with it.

The two start symbols and the two end symbols never appear on the nibble output. Everything between them is delivered the same way, preamble and frame check sequence included. A carrier flag covers each receive event. A false-carrier flag marks events that did not open with a proper start pair. A symbol-error strobe marks code groups that cannot be decoded inside a frame. If no idle is seen for a set number of code groups, lock is abandoned and the block hunts for idle again.

Top module: `fe_rx_decoder`

## Requirements
- R1: While rst_ni is low, nibble_o, data_valid_o, carrier_o, false_carrier_o, symbol_error_o and locked_o are all 0.
- R2: locked_o rises only after at least LOCK_RUN (30) consecutive descrambled ones. With idle applied from reset, it is still 0 after 25 received bits and is 1 within 60 bits.
- R3: The key sequence follows k(n) = k(n-11) xor k(n-9), which is the x^11 + x^9 + 1 generator. The received bit is plain xor key. Frames sent after lock, and again after a lock loss and relock, come out unaltered.
- R4: Code groups are taken first bit first, starting right after the pair J = 11000, K = 10001. They decode as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R5: J, K, T = 01101 and R = 00111 produce no data_valid_o. Preamble, SFD and data nibbles are all delivered. Each data_valid_o pulse lasts one cycle, in the cycle after the clock edge that samples the last bit of its group.
- R6: carrier_o rises in the cycle after the edge that samples the first descrambled zero. It falls in the cycle after the edge that samples the last bit of R.
- R7: The check window holds the two bits before the first zero, the zero itself and the seven bits after it. If this window is not J followed by K, false_carrier_o rises 8 cycles after the edge that sampled the zero. It stays high with carrier_o until 10 consecutive descrambled ones are received, and no data_valid_o is produced.
- R8: Inside a frame, a code group that is not data, T or idle gives a one-cycle symbol_error_o pulse instead of data_valid_o, and the frame continues.
- R9: Inside a frame, an idle group (11111), or a group other than R right after T, gives a symbol_error_o pulse and ends the event. carrier_o falls in the same cycle as the pulse.
- R10: After lock, if no run of 10 descrambled ones ends within TIMEOUT_GROUPS*5 bits, locked_o falls. It falls in the cycle after the edge of the last such run plus TIMEOUT_GROUPS*5. carrier_o falls one cycle later, and the block relocks on the following idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Scrambled NRZ bit, one per clock |
| nibble_o | output | 4 | Decoded data nibble |
| data_valid_o | output | 1 | One-cycle strobe for nibble_o |
| carrier_o | output | 1 | Receive event in progress |
| false_carrier_o | output | 1 | Current event lacked a valid start pair |
| symbol_error_o | output | 1 | One-cycle strobe for a bad code group in a frame |
| locked_o | output | 1 | Key generator synchronised to idle |

## Verification
The bit path has two registers: the descrambler stage and the framing stage. So a nibble strobe, a symbol error or a carrier edge appears one cycle after the edge that samples the bit which caused it. The false-carrier flag comes seven cycles after the carrier rise. A lock loss shows on locked_o in the cycle after the timeout edge and on carrier_o one cycle later. The bench tags every bit it drives with the number of the edge that will sample it, and logs each output event with its cycle number at the falling edge. Each event is then compared with the cycle computed from those rules, and no check waits or polls for a result.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_IDLE, ST_SSD, ST_FRAME, ST_TR, ST_FALSE
  } rx_state_e;

  localparam logic [4:0] CG_IDLE = 5'b11111;
  localparam logic [4:0] CG_J    = 5'b11000;
  localparam logic [4:0] CG_K    = 5'b10001;
  localparam logic [4:0] CG_T    = 5'b01101;
  localparam logic [4:0] CG_R    = 5'b00111;

  // returns {valid, nibble}
  function automatic logic [4:0] cg_decode(input logic [4:0] cg);
    logic [4:0] r;
    case (cg)
      5'b11110: r = 5'h10;
      5'b01001: r = 5'h11;
      5'b10100: r = 5'h12;
      5'b10101: r = 5'h13;
      5'b01010: r = 5'h14;
      5'b01011: r = 5'h15;
      5'b01110: r = 5'h16;
      5'b01111: r = 5'h17;
      5'b10010: r = 5'h18;
      5'b10011: r = 5'h19;
      5'b10110: r = 5'h1A;
      5'b10111: r = 5'h1B;
      5'b11010: r = 5'h1C;
      5'b11011: r = 5'h1D;
      5'b11100: r = 5'h1E;
      5'b11101: r = 5'h1F;
      default:  r = 5'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fe_rx_descrambler.sv
module fe_rx_descrambler #(
  parameter int LOCK_RUN       = 30,
  parameter int IDLE_RUN       = 10,
  parameter int TIMEOUT_GROUPS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  output logic bit_o,
  output logic idle_o,
  output logic locked_o
);
  localparam int RUN_MAX = (LOCK_RUN > IDLE_RUN) ? LOCK_RUN : IDLE_RUN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int TO_BITS = TIMEOUT_GROUPS * 5;
  localparam int TO_W    = $clog2(TO_BITS + 1);

  logic [10:0]      lfsr_q;
  logic [RUN_W-1:0] run_q, run_nx;
  logic [TO_W-1:0]  since_q;
  logic             key, plain, idle_hit;

  always_comb begin
    key   = lfsr_q[10] ^ lfsr_q[8];
    plain = rx_bit_i ^ key;
    if (!plain)                        run_nx = '0;
    else if (run_q == RUN_W'(RUN_MAX)) run_nx = run_q;
    else                               run_nx = run_q + 1'b1;
    idle_hit = (run_nx >= RUN_W'(IDLE_RUN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q   <= '0;
      run_q    <= '0;
      since_q  <= '0;
      bit_o    <= 1'b0;
      idle_o   <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      bit_o  <= plain;
      idle_o <= idle_hit;
      run_q  <= run_nx;
      if (!locked_o) begin
        // hunting: assume idle, so key estimate is the inverted line bit
        lfsr_q  <= {lfsr_q[9:0], ~rx_bit_i};
        since_q <= '0;
        if (run_nx >= RUN_W'(LOCK_RUN)) locked_o <= 1'b1;
      end else begin
        lfsr_q <= {lfsr_q[9:0], key};
        if (idle_hit) since_q <= '0;
        else if (since_q == TO_W'(TO_BITS - 1)) begin
          since_q  <= '0;
          run_q    <= '0;
          locked_o <= 1'b0;
        end else since_q <= since_q + 1'b1;
      end
    end
  end

  assert_lock_on_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> bit_o);

  assert_drop_no_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> !idle_o);
endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer
  import fe_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       idle_i,
  input  logic       locked_i,
  output logic [3:0] nibble_o,
  output logic       data_valid_o,
  output logic       carrier_o,
  output logic       false_carrier_o,
  output logic       symbol_error_o
);
  rx_state_e   state_q;
  logic [8:0]  sr_q;
  logic [2:0]  cnt_q;
  logic [9:0]  window;
  logic [4:0]  grp, dec;

  assign window = {sr_q, bit_i};
  assign grp    = window[4:0];
  assign dec    = cg_decode(grp);

  assign carrier_o       = (state_q == ST_SSD) || (state_q == ST_FRAME) ||
                           (state_q == ST_TR)  || (state_q == ST_FALSE);
  assign false_carrier_o = (state_q == ST_FALSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_HUNT;
      sr_q           <= '0;
      cnt_q          <= '0;
      nibble_o       <= '0;
      data_valid_o   <= 1'b0;
      symbol_error_o <= 1'b0;
    end else begin
      sr_q           <= window[8:0];
      data_valid_o   <= 1'b0;
      symbol_error_o <= 1'b0;
      if (!locked_i) begin
        state_q <= ST_HUNT;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_HUNT: state_q <= ST_IDLE;
          ST_IDLE: if (!bit_i) begin
            state_q <= ST_SSD;
            cnt_q   <= '0;
          end
          ST_SSD: begin
            if (cnt_q == 3'd6) begin
              cnt_q   <= '0;
              state_q <= (window == {CG_J, CG_K}) ? ST_FRAME : ST_FALSE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_FRAME: begin
            if (cnt_q == 3'd4) begin
              cnt_q <= '0;
              if (grp == CG_T) state_q <= ST_TR;
              else if (grp == CG_IDLE) begin
                symbol_error_o <= 1'b1;
                state_q        <= ST_IDLE;
              end else if (dec[4]) begin
                nibble_o     <= dec[3:0];
                data_valid_o <= 1'b1;
              end else symbol_error_o <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_TR: begin
            if (cnt_q == 3'd4) begin
              cnt_q          <= '0;
              symbol_error_o <= (grp != CG_R);
              state_q        <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_FALSE: if (idle_i) state_q <= ST_IDLE;
          default:  state_q <= ST_HUNT;
        endcase
      end
    end
  end

  assert_dv_se_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_valid_o && symbol_error_o));

  assert_false_has_carrier_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_carrier_o |-> carrier_o);

  assert_dv_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (carrier_o && !false_carrier_o));

  assert_unlock_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> !carrier_o);
endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
  parameter int LOCK_RUN       = 30,
  parameter int IDLE_RUN       = 10,
  parameter int TIMEOUT_GROUPS = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_bit_i,
  output logic [3:0] nibble_o,
  output logic       data_valid_o,
  output logic       carrier_o,
  output logic       false_carrier_o,
  output logic       symbol_error_o,
  output logic       locked_o
);
  logic plain_bit, idle_run, locked;

  fe_rx_descrambler #(
    .LOCK_RUN(LOCK_RUN), .IDLE_RUN(IDLE_RUN), .TIMEOUT_GROUPS(TIMEOUT_GROUPS)
  ) u_descr (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_bit_i(rx_bit_i),
    .bit_o(plain_bit), .idle_o(idle_run), .locked_o(locked)
  );

  fe_rx_framer u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(plain_bit), .idle_i(idle_run),
    .locked_i(locked), .nibble_o(nibble_o), .data_valid_o(data_valid_o),
    .carrier_o(carrier_o), .false_carrier_o(false_carrier_o),
    .symbol_error_o(symbol_error_o)
  );

  assign locked_o = locked;
endmodule

// File: tb/fe_rx_decoder_bench.sv
module fe_rx_decoder_bench;
  localparam int TO_G    = 32;
  localparam int TO_BITS = TO_G * 5;

  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b1;
  logic [3:0] nibble;
  logic dv, car, fcar, serr, lck;
  always #4 clk = ~clk;

  fe_rx_decoder #(.LOCK_RUN(30), .IDLE_RUN(10), .TIMEOUT_GROUPS(TO_G)) u_fe_rx_decoder (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .nibble_o(nibble),
    .data_valid_o(dv), .carrier_o(car), .false_carrier_o(fcar),
    .symbol_error_o(serr), .locked_o(lck)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_err = 0;
  bit done = 0;
  int nib_q[$], dv_cyc[$], se_cyc[$], cr_cyc[$], cf_cyc[$], fc_cyc[$], lf_cyc[$];
  logic car_p = 0, fc_p = 0, lk_p = 0;

  always @(negedge clk) begin
    if (dv) begin nib_q.push_back(int'(nibble)); dv_cyc.push_back(cyc); end
    if (serr) se_cyc.push_back(cyc);
    if (car && !car_p) cr_cyc.push_back(cyc);
    if (!car && car_p) cf_cyc.push_back(cyc);
    if (fcar && !fc_p) fc_cyc.push_back(cyc);
    if (!lck && lk_p) lf_cyc.push_back(cyc);
    car_p = car; fc_p = fcar; lk_p = lck;
  end

  logic [10:0] scr;
  int last_pos;
  logic [4:0] grp [80];
  int gpos [80];
  int ngrp;
  int dix[$], exp_nib[$];

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_plain(input logic p);
    logic k;
    @(negedge clk);
    k = scr[10] ^ scr[8];
    scr = {scr[9:0], k};
    rx_bit = p ^ k;
    last_pos = cyc + 1;
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_plain(1'b1);
  endtask

  task automatic new_frame;
    ngrp = 0; dix.delete(); exp_nib.delete();
    nib_q.delete(); dv_cyc.delete(); se_cyc.delete();
    cr_cyc.delete(); cf_cyc.delete(); fc_cyc.delete(); lf_cyc.delete();
  endtask

  task automatic add_grp(input logic [4:0] g);
    grp[ngrp] = g; ngrp++;
  endtask

  task automatic add_data(input int n);
    dix.push_back(ngrp); exp_nib.push_back(n); add_grp(enc(n));
  endtask

  task automatic send_all;
    for (int i = 0; i < ngrp; i++) begin
      for (int b = 4; b >= 0; b--) send_plain(grp[i][b]);
      gpos[i] = last_pos;
    end
    send_idle(40);
  endtask

  task automatic check_data(input string req);
    int bad_n = 0, bad_c = 0;
    check(nib_q.size() == exp_nib.size(), "R5", "nibble count", nib_q.size(), exp_nib.size());
    for (int k = 0; k < exp_nib.size() && k < nib_q.size(); k++) begin
      if (nib_q[k] != exp_nib[k]) begin
        bad_n++;
        $display("FAIL %s nibble %0d: actual %0d expected %0d", req, k, nib_q[k], exp_nib[k]);
      end
      if (dv_cyc[k] != gpos[dix[k]] + 1) begin
        bad_c++;
        $display("FAIL R5 valid cycle %0d: actual %0d expected %0d", k, dv_cyc[k], gpos[dix[k]] + 1);
      end
    end
    n_checks += 2;
    if (bad_n != 0) n_err++;
    if (bad_c != 0) n_err++;
  endtask

  task automatic check_normal(input string req);
    check_data(req);
    check(se_cyc.size() == 0, "R8", "no symbol error", se_cyc.size(), 0);
    check(fc_cyc.size() == 0, "R7", "no false carrier", fc_cyc.size(), 0);
    check(cr_cyc.size() == 1 && cr_cyc[0] == gpos[0] - 1, "R6", "carrier rise",
          cr_cyc.size() > 0 ? cr_cyc[0] : -1, gpos[0] - 1);
    check(cf_cyc.size() == 1 && cf_cyc[0] == gpos[ngrp-1] + 1, "R6", "carrier fall",
          cf_cyc.size() > 0 ? cf_cyc[0] : -1, gpos[ngrp-1] + 1);
  endtask

  initial begin
    scr = 11'h4B1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({nibble, dv, car, fcar, serr, lck} == 9'd0, "R1", "outputs in reset",
          int'({nibble, dv, car, fcar, serr, lck}), 0);
    rst_n = 1'b1;

    // R2 lock needs a run of 30 ones
    send_idle(25);
    check(lck == 1'b0, "R2", "not locked after 25 bits", lck, 0);
    send_idle(35);
    check(lck == 1'b1, "R2", "locked after 60 bits", lck, 1);
    send_idle(20);

    // R4 sweep: every first nibble followed by every second nibble
    for (int a = 0; a < 16; a++) begin
      new_frame();
      add_grp(5'b11000); add_grp(5'b10001);
      add_data(5); add_data(13); add_data(a);
      for (int b = 0; b < 16; b++) add_data(b);
      add_grp(5'b01101); add_grp(5'b00111);
      send_all();
      check_normal("R4");
    end

    // R8 invalid group mid-frame
    new_frame();
    add_grp(5'b11000); add_grp(5'b10001);
    add_data(5); add_data(5); add_grp(5'b00000); add_data(3); add_data(4);
    add_grp(5'b01101); add_grp(5'b00111);
    send_all();
    check_data("R8");
    check(se_cyc.size() == 1 && se_cyc[0] == gpos[4] + 1, "R8", "error pulse cycle",
          se_cyc.size() > 0 ? se_cyc[0] : -1, gpos[4] + 1);
    check(cf_cyc.size() == 1 && cf_cyc[0] == gpos[ngrp-1] + 1, "R8", "frame continues",
          cf_cyc.size() > 0 ? cf_cyc[0] : -1, gpos[ngrp-1] + 1);

    // R9 T followed by idle instead of R
    new_frame();
    add_grp(5'b11000); add_grp(5'b10001); add_data(7);
    add_grp(5'b01101); add_grp(5'b11111);
    send_all();
    check_data("R9");
    check(se_cyc.size() == 1 && se_cyc[0] == gpos[4] + 1, "R9", "T without R error",
          se_cyc.size() > 0 ? se_cyc[0] : -1, gpos[4] + 1);
    check(cf_cyc.size() == 1 && cf_cyc[0] == gpos[4] + 1, "R9", "T without R carrier fall",
          cf_cyc.size() > 0 ? cf_cyc[0] : -1, gpos[4] + 1);

    // R9 idle group inside frame
    new_frame();
    add_grp(5'b11000); add_grp(5'b10001); add_data(9); add_grp(5'b11111);
    send_all();
    check_data("R9");
    check(se_cyc.size() == 1 && se_cyc[0] == gpos[3] + 1, "R9", "idle in frame error",
          se_cyc.size() > 0 ? se_cyc[0] : -1, gpos[3] + 1);
    check(cf_cyc.size() == 1 && cf_cyc[0] == gpos[3] + 1, "R9", "idle in frame carrier fall",
          cf_cyc.size() > 0 ? cf_cyc[0] : -1, gpos[3] + 1);

    // R7 false carrier: bad start pair
    new_frame();
    add_grp(5'b11110); add_grp(5'b01001);
    send_all();
    check(nib_q.size() == 0, "R7", "no data on false carrier", nib_q.size(), 0);
    check(cr_cyc.size() == 1 && cr_cyc[0] == gpos[0] + 1, "R7", "carrier rise",
          cr_cyc.size() > 0 ? cr_cyc[0] : -1, gpos[0] + 1);
    check(fc_cyc.size() == 1 && fc_cyc[0] == gpos[0] + 8, "R7", "false carrier rise",
          fc_cyc.size() > 0 ? fc_cyc[0] : -1, gpos[0] + 8);
    check(cf_cyc.size() == 1 && !car && !fcar, "R7", "event ended on idle", cf_cyc.size(), 1);

    // R10 lock timeout on an over-long event, then relock
    new_frame();
    add_grp(5'b11000); add_grp(5'b10001);
    for (int i = 0; i < 40; i++) add_data(i % 16);
    for (int i = 0; i < ngrp; i++) begin
      for (int b = 4; b >= 0; b--) send_plain(grp[i][b]);
      gpos[i] = last_pos;
    end
    check(lf_cyc.size() == 1 && lf_cyc[0] == gpos[0] - 3 + TO_BITS, "R10", "lock drop cycle",
          lf_cyc.size() > 0 ? lf_cyc[0] : -1, gpos[0] - 3 + TO_BITS);
    check(cf_cyc.size() == 1 && lf_cyc.size() == 1 && cf_cyc[0] == lf_cyc[0] + 1, "R10",
          "carrier drops after lock", cf_cyc.size() > 0 ? cf_cyc[0] : -1,
          lf_cyc.size() > 0 ? lf_cyc[0] + 1 : -1);
    send_idle(80);
    check(lck == 1'b1, "R10", "relock on idle", lck, 1);

    // R3 data after relock
    new_frame();
    add_grp(5'b11000); add_grp(5'b10001);
    for (int i = 0; i < 8; i++) add_data((i * 7 + 3) % 16);
    add_grp(5'b01101); add_grp(5'b00111);
    send_all();
    check_normal("R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule